// File: doc/BRIEF.md
# Distributed Multiprocessor Bus Arbiter Node

This block is the arbitration logic that sits in each of up to six identical processors sharing one external bus. There is no central arbiter. Every node keeps its own copy of the bus state, built from the same view of the six active-low request lines. Because every copy is updated by the same rule on the same clock edge, all nodes agree on who owns the bus without exchanging any other signal.

A node learns its position from a 3-bit identity that it captures during reset. That identity decides which of the six request lines the node drives. It watches the other five lines as inputs. A mode input selects fixed or rotating priority. All nodes must see the same mode value, and a change applies at the next deciding edge. A shared active-low priority-access line lets a bus slave claim the bus: a master that is only doing background DMA withdraws its request while the line is low.

Identity 0 selects single-processor operation. In that case the node owns the bus permanently and drives no request line. The output flag tells the local processor when it is the bus master.

Top module: `mpb_arb_node`

## Requirements
- R1: While reset is high and on the first cycle after it, with a non-zero identity, `bus_master` is low and all six `req_n_out` bits are high. The rotating-priority start position is reset to node 1.
- R2: With a captured identity n (1..6), `req_n_out[n-1]` goes low one clock edge after `want_bus` is seen high and the other five bits stay high. The identity is captured only while reset is high, so later changes on `node_id` have no effect.
- R3: With identity 0 captured, `bus_master` is high from the first edge of reset onward and every `req_n_out` bit stays high, whatever `want_bus` is.
- R4: With `rot_mode` low and the bus idle, the lowest-numbered active request line wins, where line index i stands for node i+1. The winner becomes owner on the edge at which the requests are first seen together.
- R5: With `rot_mode` high, after node k releases the bus, node (k mod 6)+1 has top priority and priority falls cyclically upward from it. After reset, node 1 has top priority.
- R6: A master keeps the bus as long as its own request line stays active, even while higher-priority lines are active.
- R7: The owner of a released bus is cleared on the edge at which its request is first seen inactive. A new owner is chosen no earlier than the following edge, so there is always at least one idle cycle between masters.
- R8: Inactive (high) request lines never win. With no active request the bus stays idle and `bus_master` stays low.
- R9: While `prio_acc_n` is low and `dma_bg` is high, the node's own request goes inactive on the next edge, so a master releases the bus one edge later. With `dma_bg` low, `prio_acc_n` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; identity captured while high |
| node_id | input | 3 | Hardwired node identity (0 = single processor, 1..6 = request line) |
| rot_mode | input | 1 | 1 = rotating priority, 0 = fixed priority |
| want_bus | input | 1 | Local processor requests the shared bus |
| dma_bg | input | 1 | Local bus activity is background DMA that may be pre-empted |
| prio_acc_n | input | 1 | Shared active-low priority-access line from a bus slave |
| req_n_in | input | 6 | Observed active-low request lines of all nodes (own bit ignored) |
| req_n_out | output | 6 | Active-low request lines; only the bit of the own identity ever goes low |
| bus_master | output | 1 | High while this node owns the shared bus |

## Verification
The own request line changes one edge after `want_bus`. Ownership follows one edge after the request set becomes visible, so `bus_master` rises two edges after the node's own request and one edge after other nodes' lines change. The bench therefore raises `want_bus` one edge before it drives the other lines, which lets all requests reach the decision together. It samples 1 ns after the edge at which each result is due. A release is checked at both edges of the handover: the owner clears on the first and the next winner takes the bus on the second. A priority-access withdrawal is checked on the request line after one edge and on the master flag after two.

// File: rtl/mpb_pkg.sv
package mpb_pkg;
    localparam int NODES = 6;
    localparam int IDW   = 3;

    typedef logic [IDW-1:0] node_id_t;
endpackage

// File: rtl/mpb_prio_pick.sv
module mpb_prio_pick #(
    parameter int N = mpb_pkg::NODES,
    parameter int W = mpb_pkg::IDW
) (
    input  logic [N-1:0] reqv,
    input  logic [W-1:0] start_id,
    output logic         found,
    output logic [W-1:0] win_id
);
    localparam int DBL = 2 * N;

    logic [DBL-1:0] dbl;
    logic [N-1:0]   rotated;
    int             base;

    assign dbl = {reqv, reqv};

    always_comb begin
        if (start_id == '0 || int'(start_id) > N) begin
            base = 0;
        end else begin
            base = int'(start_id) - 1;
        end
    end

    assign rotated = dbl[base +: N];

    // First active line at or after the start position, wrapping around
    always_comb begin
        found  = 1'b0;
        win_id = '0;
        for (int off = 0; off < N; off++) begin
            if (!found && rotated[off]) begin
                found = 1'b1;
                if (base + off >= N) begin
                    win_id = W'(base + off - N + 1);
                end else begin
                    win_id = W'(base + off + 1);
                end
            end
        end
    end
endmodule

// File: rtl/mpb_req_ctrl.sv
module mpb_req_ctrl #(
    parameter int N = mpb_pkg::NODES,
    parameter int W = mpb_pkg::IDW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] node_id,
    input  logic         want_bus,
    input  logic         dma_bg,
    input  logic         prio_acc_n,
    output logic [W-1:0] id_q,
    output logic         own_req_q,
    output logic [N-1:0] req_n_out
);
    typedef struct packed {
        logic [W-1:0] id;
        logic         own_req;
    } req_state_t;

    req_state_t st_d, st_q;
    logic       id_valid;
    logic       preempt;

    assign id_valid = (st_q.id != '0) && (st_q.id <= W'(N));
    assign preempt  = !prio_acc_n && dma_bg;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.id      = node_id;
            st_d.own_req = 1'b0;
        end else begin
            st_d.own_req = id_valid && want_bus && !preempt;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign id_q      = st_q.id;
    assign own_req_q = st_q.own_req;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign req_n_out[i] = !(st_q.own_req && st_q.id == W'(i + 1));
    end

    assert_one_line_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~req_n_out));

    assert_pa_withdraw_R9: assert property (@(posedge clk) disable iff (rst)
        (!prio_acc_n && dma_bg) |=> !own_req_q);
endmodule

// File: rtl/mpb_owner_track.sv
module mpb_owner_track #(
    parameter int N = mpb_pkg::NODES,
    parameter int W = mpb_pkg::IDW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] reqv,
    input  logic         win_found,
    input  logic [W-1:0] win_id,
    output logic [W-1:0] owner_q,
    output logic [W-1:0] top_q
);
    typedef struct packed {
        logic [W-1:0] owner;
        logic [W-1:0] top;
    } own_state_t;

    own_state_t st_d, st_q;
    logic [N-1:0] owner_mask;
    logic         owner_held;

    for (genvar i = 0; i < N; i++) begin : g_mask
        assign owner_mask[i] = (st_q.owner == W'(i + 1));
    end

    assign owner_held = |(owner_mask & reqv);

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.owner = '0;
            st_d.top   = W'(1);
        end else if (st_q.owner != '0) begin
            if (!owner_held) begin
                st_d.owner = '0;
                st_d.top   = (st_q.owner >= W'(N)) ? W'(1) : st_q.owner + W'(1);
            end
        end else if (win_found) begin
            st_d.owner = win_id;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign owner_q = st_q.owner;
    assign top_q   = st_q.top;

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (owner_q != '0 && owner_held) |=> $stable(owner_q));

    assert_idle_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (owner_q != '0 && !owner_held) |=> (owner_q == '0));

    assert_no_phantom_R8: assert property (@(posedge clk) disable iff (rst)
        (owner_q == '0 && reqv == '0) |=> (owner_q == '0));

    assert_top_range_R5: assert property (@(posedge clk) disable iff (rst)
        (top_q != '0) && (top_q <= W'(N)));
endmodule

// File: rtl/mpb_arb_node.sv
module mpb_arb_node #(
    parameter int N = mpb_pkg::NODES,
    parameter int W = mpb_pkg::IDW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] node_id,
    input  logic         rot_mode,
    input  logic         want_bus,
    input  logic         dma_bg,
    input  logic         prio_acc_n,
    input  logic [N-1:0] req_n_in,
    output logic [N-1:0] req_n_out,
    output logic         bus_master
);
    logic [W-1:0] id_q;
    logic         own_req_q;
    logic [N-1:0] reqv;
    logic [W-1:0] owner_q;
    logic [W-1:0] top_q;
    logic [W-1:0] start_id;
    logic         win_found;
    logic [W-1:0] win_id;

    mpb_req_ctrl #(.N(N), .W(W)) req_i (
        .clk        (clk),
        .rst        (rst),
        .node_id    (node_id),
        .want_bus   (want_bus),
        .dma_bg     (dma_bg),
        .prio_acc_n (prio_acc_n),
        .id_q       (id_q),
        .own_req_q  (own_req_q),
        .req_n_out  (req_n_out)
    );

    // Shared view: own line from internal state, others from the bus
    for (genvar i = 0; i < N; i++) begin : g_view
        assign reqv[i] = (id_q == W'(i + 1)) ? own_req_q : !req_n_in[i];
    end

    assign start_id = rot_mode ? top_q : W'(1);

    mpb_prio_pick #(.N(N), .W(W)) pick_i (
        .reqv     (reqv),
        .start_id (start_id),
        .found    (win_found),
        .win_id   (win_id)
    );

    mpb_owner_track #(.N(N), .W(W)) own_i (
        .clk       (clk),
        .rst       (rst),
        .reqv      (reqv),
        .win_found (win_found),
        .win_id    (win_id),
        .owner_q   (owner_q),
        .top_q     (top_q)
    );

    assign bus_master = (id_q == '0) || (owner_q == id_q);

    assert_single_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (id_q == '0) |-> (&req_n_out));

    assert_master_grant_R4: assert property (@(posedge clk) disable iff (rst)
        ($rose(bus_master) && id_q != '0) |-> $past(own_req_q));
endmodule

// File: tb/mpb_arb_node_tb_top.sv
`timescale 1ns/1ps
module mpb_arb_node_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] node_id = 3'd0;
    logic       rot_mode = 1'b0;
    logic       want_bus = 1'b0;
    logic       dma_bg = 1'b0;
    logic       prio_acc_n = 1'b1;
    logic [5:0] req_n_in = 6'h3F;
    logic [5:0] req_n_out;
    logic       bus_master;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    mpb_arb_node dut_i (
        .clk(clk), .rst(rst), .node_id(node_id), .rot_mode(rot_mode),
        .want_bus(want_bus), .dma_bg(dma_bg), .prio_acc_n(prio_acc_n),
        .req_n_in(req_n_in), .req_n_out(req_n_out), .bus_master(bus_master)
    );

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(bit ok, string tag, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int fix_win(logic [5:0] p);
        for (int i = 0; i < 6; i++) if (p[i]) return i + 1;
        return 0;
    endfunction

    function automatic int rot_win(logic [5:0] p, int top);
        for (int off = 0; off < 6; off++) begin
            int idx = (top - 1 + off) % 6;
            if (p[idx]) return idx + 1;
        end
        return 0;
    endfunction

    task automatic do_reset(int id);
        node_id = 3'(id);
        want_bus = 0; req_n_in = 6'h3F; prio_acc_n = 1; dma_bg = 0;
        rst = 1;
        tick(2);
        rst = 0;
    endtask

    // Own request one edge earlier, then the others, then sample
    task automatic apply_pattern(int id, logic [5:0] p);
        want_bus = p[id-1];
        req_n_in = 6'h3F;
        tick();
        req_n_in = ~p | (6'd1 << (id - 1));
        tick();
    endtask

    task automatic release_all();
        want_bus = 0;
        req_n_in = 6'h3F;
        tick(3);
    endtask

    initial begin
        // R1: reset state
        do_reset(2);
        check(bus_master == 0, "R1 master after reset", bus_master, 0);
        check(req_n_out == 6'h3F, "R1 lines after reset", req_n_out, 6'h3F);
        // R5/R1: rotating start position is node 1 after reset
        rot_mode = 1;
        apply_pattern(2, 6'b000011);
        check(bus_master == 0, "R1 rotation start at node 1", bus_master, 0);
        release_all();

        // R4, R2, R6, R8: fixed priority sweep
        for (int id = 1; id <= 6; id++) begin
            do_reset(id);
            rot_mode = 0;
            for (int pi = 0; pi < 64; pi++) begin
                logic [5:0] p = 6'(pi);
                int exp = fix_win(p);
                apply_pattern(id, p);
                check(bus_master == (exp == id), "R4 fixed winner",
                      bus_master, int'(exp == id));
                check(req_n_out == ~(6'(p[id-1]) << (id - 1)), "R2 own line only",
                      req_n_out, ~(6'(p[id-1]) << (id - 1)) & 6'h3F);
                if (p == 0) check(bus_master == 0, "R8 idle bus", bus_master, 0);
                tick();
                check(bus_master == (exp == id), "R6 hold while requesting",
                      bus_master, int'(exp == id));
                release_all();
            end
        end

        // R5: rotating priority sweep
        for (int id = 1; id <= 6; id++) begin
            do_reset(id);
            rot_mode = 1;
            for (int k = 1; k <= 6; k++) begin
                for (int pi = 0; pi < 64; pi++) begin
                    logic [5:0] p = 6'(pi);
                    int exp = rot_win(p, (k % 6) + 1);
                    if (k == id) want_bus = 1;
                    else req_n_in = ~(6'd1 << (k - 1));
                    tick(3);
                    release_all();
                    apply_pattern(id, p);
                    check(bus_master == (exp == id), "R5 rotating winner",
                          bus_master, int'(exp == id));
                    release_all();
                end
            end
        end

        // R7, R6, R9: handover, hold and priority access with node 3
        do_reset(3);
        rot_mode = 0;
        req_n_in = 6'b111110;
        tick();
        want_bus = 1;
        tick(2);
        check(bus_master == 0, "R6 other master holds", bus_master, 0);
        req_n_in = 6'h3F;
        tick();
        check(bus_master == 0, "R7 idle cycle", bus_master, 0);
        tick();
        check(bus_master == 1, "R7 next master", bus_master, 1);
        req_n_in = 6'b111110;
        tick(2);
        check(bus_master == 1, "R6 keep despite higher request", bus_master, 1);
        dma_bg = 1; prio_acc_n = 0;
        tick();
        check(req_n_out[2] == 1, "R9 request withdrawn", req_n_out[2], 1);
        tick();
        check(bus_master == 0, "R9 bus released", bus_master, 0);
        prio_acc_n = 1; dma_bg = 0;
        req_n_in = 6'h3F;
        tick(3);
        check(bus_master == 1, "R9 regains after access", bus_master, 1);
        prio_acc_n = 0;
        tick(2);
        check(bus_master == 1, "R9 no effect without dma", bus_master, 1);
        check(req_n_out[2] == 0, "R9 line kept without dma", req_n_out[2], 0);
        prio_acc_n = 1;
        release_all();

        // R2: identity changes after reset are ignored
        node_id = 3'd5;
        want_bus = 1;
        tick();
        check(req_n_out == 6'b111011, "R2 identity held", req_n_out, 6'b111011);
        release_all();

        // R3: single-processor mode
        do_reset(0);
        check(bus_master == 1, "R3 master in single mode", bus_master, 1);
        want_bus = 1;
        req_n_in = 6'b000000;
        tick(3);
        check(bus_master == 1, "R3 master kept", bus_master, 1);
        check(req_n_out == 6'h3F, "R3 no line driven", req_n_out, 6'h3F);
        release_all();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule